// File: doc/BRIEF.md
# Configuration Register Loader

This block holds the small set of 8-bit configuration registers that set up a dual-sampler acquisition board. These cover band and attenuation for each sampler, the sampler-select and speed field of the interface, and two LO frequency bytes. The decoded fields drive the rest of the board directly.

Two sources can write the registers. The first is a remote 16-bit word from a DMA card, strobed by a request line and answered with an acknowledge. The second is a pair of 8-bit switch banks written by an enter push-button. A mode switch chooses the source. While it selects manual entry, remote traffic has no effect. Remote words are taken only while the data-direction control is low, which means the host is sending configuration. The request, the button, the mode switch and the direction control are all synchronised into the system clock. The button is also debounced, so each press writes once.

Top module: `cfg_loader`

## Requirements
- R1: In remote mode with direction low, a rising request writes data bits 7:0 of the remote word into the register addressed by bits 15:8. The acknowledge output then goes high.
- R2: Acknowledge stays high while the request is held and returns low after the request is released.
- R3: While the direction input is high, a remote request is neither acknowledged nor written.
- R4: While the mode input selects manual (high), a remote request is neither acknowledged nor written.
- R5: In manual mode, a debounced press of the enter button writes the data switches into the register at the address switches. In remote mode, the button has no effect.
- R6: A button level that lasts fewer than DEBOUNCE_CYCLES clocks writes nothing. A held press writes exactly once, even if the switches change while the button is held.
- R7: Addresses 0 and 1 are sampler 0 and sampler 1. In each, bit 6 is the band select, bits 5:3 are the right attenuation in dB and bits 2:0 are the left attenuation in dB. Bit 7 is dropped.
- R8: Address 2 carries the sampler select in bits 4:3 and the speed code in bits 2:0. Bits 7:5 are dropped.
- R9: Addresses 4 and 5 hold the LO0 and LO1 frequency bytes in full.
- R10: A remote write to address 3 or to any address above 5 is acknowledged but changes no output.
- R11: Asynchronous reset clears every register to zero, giving no samplers selected and speed code 000, and drops the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| manual_i | input | 1 | Source select: 1 = switches, 0 = remote |
| dir_i | input | 1 | Data direction; remote writes need 0 |
| rem_req_i | input | 1 | Remote write request strobe |
| rem_word_i | input | 16 | Remote word: address 15:8, data 7:0 |
| rem_ack_o | output | 1 | Remote acknowledge |
| sw_addr_i | input | 8 | Address switch bank |
| sw_data_i | input | 8 | Data switch bank |
| enter_i | input | 1 | Enter push-button, raw |
| smp0_band_o | output | 1 | Sampler 0 band select |
| smp0_att_r_o | output | 3 | Sampler 0 right attenuation, dB |
| smp0_att_l_o | output | 3 | Sampler 0 left attenuation, dB |
| smp1_band_o | output | 1 | Sampler 1 band select |
| smp1_att_r_o | output | 3 | Sampler 1 right attenuation, dB |
| smp1_att_l_o | output | 3 | Sampler 1 left attenuation, dB |
| smp_sel_o | output | 2 | Sampler select field |
| speed_o | output | 3 | Speed code |
| lo0_freq_o | output | 8 | LO0 frequency byte |
| lo1_freq_o | output | 8 | LO1 frequency byte |

## Verification
The bench sends remote words with bit 7 set and with spare high bits in the interface register. A design that packs fields at the wrong offsets, or lets the dropped bits leak through, shows wrong band, attenuation or speed values. It sends requests while direction is high, while manual mode is selected, and to unmapped addresses 3 and 7. A design that acknowledges a blocked request, or that aliases an unmapped address onto a real register, is caught there. On the manual side, it applies a three-cycle button glitch, holds a press while the data switches change, and presses the button in remote mode. A design without a proper debounce, or one that writes on the level instead of the edge, overwrites a register it should have left alone.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned WORD_W = ADDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] ADDR_SMP0 = 8'd0;
  localparam logic [ADDR_W-1:0] ADDR_SMP1 = 8'd1;
  localparam logic [ADDR_W-1:0] ADDR_IFC  = 8'd2;
  localparam logic [ADDR_W-1:0] ADDR_LO0  = 8'd4;
  localparam logic [ADDR_W-1:0] ADDR_LO1  = 8'd5;

  typedef struct packed {
    logic       band;
    logic [2:0] att_r;
    logic [2:0] att_l;
  } smp_cfg_t;

  typedef struct packed {
    logic [1:0] sel;
    logic [2:0] speed;
  } ifc_cfg_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_debounce.sv
module cfg_debounce #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic press_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic             stable_q;
  logic             press_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stable_q <= 1'b0;
      press_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      press_q <= 1'b0;
      if (btn_i != stable_q) begin
        if (cnt_q == CNT_W'(LIMIT - 1)) begin
          stable_q <= btn_i;
          press_q  <= btn_i;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign press_o = press_q;

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_q |=> !press_q);
  a_r6_press_on_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_q |-> stable_q);
endmodule

// File: rtl/cfg_remote_rx.sv
module cfg_remote_rx
  import cfg_loader_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              block_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ack_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              req_d_q;
  logic              ack_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign accept = req_i && !req_d_q && !block_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d_q <= 1'b0;
      ack_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      req_d_q <= req_i;
      we_q    <= accept;
      if (accept) {addr_q, data_q} <= word_i;
      if (!req_i)      ack_q <= 1'b0;
      else if (accept) ack_q <= 1'b1;
    end
  end

  assign ack_o  = ack_q;
  assign we_o   = we_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  a_r2_ack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q && req_i |=> ack_q);
  a_r2_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_q);
  a_r3_blocked_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(!block_i));
  a_r1_ack_with_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> we_q);
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_loader_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output smp_cfg_t          smp0_o,
  output smp_cfg_t          smp1_o,
  output ifc_cfg_t          ifc_o,
  output logic [DATA_W-1:0] lo0_o,
  output logic [DATA_W-1:0] lo1_o
);
  smp_cfg_t          smp_q [2];
  ifc_cfg_t          ifc_q;
  logic [DATA_W-1:0] lo_q  [2];

  for (genvar g = 0; g < 2; g++) begin : g_chan
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        smp_q[g] <= '0;
        lo_q[g]  <= '0;
      end else if (we_i) begin
        if (addr_i == ADDR_SMP0 + ADDR_W'(g)) smp_q[g] <= data_i[6:0];
        if (addr_i == ADDR_LO0 + ADDR_W'(g))  lo_q[g]  <= data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ifc_q <= '0;
    else if (we_i && addr_i == ADDR_IFC) ifc_q <= data_i[4:0];
  end

  assign smp0_o = smp_q[0];
  assign smp1_o = smp_q[1];
  assign ifc_o  = ifc_q;
  assign lo0_o  = lo_q[0];
  assign lo1_o  = lo_q[1];

  a_r10_unmapped_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (addr_i == 8'd3 || addr_i > ADDR_LO1)
    |=> $stable({smp0_o, smp1_o, ifc_o, lo0_o, lo1_o}));
  a_r9_lo1_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_LO1 |=> lo1_o == $past(data_i));
  a_r8_ifc_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_IFC |=> ifc_o.speed == $past(data_i[2:0]));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYCLES = 16,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        manual_i,
  input  logic        dir_i,
  input  logic        rem_req_i,
  input  logic [15:0] rem_word_i,
  output logic        rem_ack_o,
  input  logic [7:0]  sw_addr_i,
  input  logic [7:0]  sw_data_i,
  input  logic        enter_i,
  output logic        smp0_band_o,
  output logic [2:0]  smp0_att_r_o,
  output logic [2:0]  smp0_att_l_o,
  output logic        smp1_band_o,
  output logic [2:0]  smp1_att_r_o,
  output logic [2:0]  smp1_att_l_o,
  output logic [1:0]  smp_sel_o,
  output logic [2:0]  speed_o,
  output logic [7:0]  lo0_freq_o,
  output logic [7:0]  lo1_freq_o
);
  logic              manual_s, dir_s, req_s, btn_s;
  logic              press;
  logic              rem_we;
  logic [ADDR_W-1:0] rem_addr;
  logic [DATA_W-1:0] rem_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  smp_cfg_t          smp0, smp1;
  ifc_cfg_t          ifc;

  cfg_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({manual_i, dir_i, rem_req_i, enter_i}),
    .q_o   ({manual_s, dir_s, req_s, btn_s})
  );

  cfg_debounce #(.LIMIT(DEBOUNCE_CYCLES)) u_deb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_i  (btn_s),
    .press_o(press)
  );

  cfg_remote_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_s),
    .block_i(manual_s || dir_s),
    .word_i (rem_word_i),
    .ack_o  (rem_ack_o),
    .we_o   (rem_we),
    .addr_o (rem_addr),
    .data_o (rem_data)
  );

  // manual path wins; remote is already gated off in manual mode
  always_comb begin
    if (press && manual_s) begin
      wr_en   = 1'b1;
      wr_addr = sw_addr_i;
      wr_data = sw_data_i;
    end else begin
      wr_en   = rem_we;
      wr_addr = rem_addr;
      wr_data = rem_data;
    end
  end

  cfg_regbank u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_en),
    .addr_i(wr_addr),
    .data_i(wr_data),
    .smp0_o(smp0),
    .smp1_o(smp1),
    .ifc_o (ifc),
    .lo0_o (lo0_freq_o),
    .lo1_o (lo1_freq_o)
  );

  assign smp0_band_o  = smp0.band;
  assign smp0_att_r_o = smp0.att_r;
  assign smp0_att_l_o = smp0.att_l;
  assign smp1_band_o  = smp1.band;
  assign smp1_att_r_o = smp1.att_r;
  assign smp1_att_l_o = smp1.att_l;
  assign smp_sel_o    = ifc.sel;
  assign speed_o      = ifc.speed;

  a_r4_manual_no_remote: assert property (@(posedge clk_i) disable iff (!rst_ni)
    manual_s && $past(manual_s) |-> !rem_we);
  a_r5_button_needs_manual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en && !rem_we |-> manual_s);
endmodule

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;
  localparam int unsigned DEB = 16;
  localparam int unsigned NVEC = 8;
  // {remote word, expected view of the written address}
  localparam logic [23:0] VEC [NVEC] = '{
    {16'h00A9, 8'h29}, {16'h0146, 8'h46}, {16'h02FF, 8'h1F}, {16'h0215, 8'h15},
    {16'h04C3, 8'hC3}, {16'h053C, 8'h3C}, {16'h00FF, 8'h7F}, {16'h01C0, 8'h40}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic manual = 1'b0, dir = 1'b0, req = 1'b0, enter = 1'b0;
  logic [15:0] word = '0;
  logic [7:0] sw_addr = '0, sw_data = '0;
  logic ack, b0, b1;
  logic [2:0] r0, l0, r1, l1, spd;
  logic [1:0] sel;
  logic [7:0] lo0, lo1;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  cfg_loader #(.DEBOUNCE_CYCLES(DEB)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .manual_i(manual), .dir_i(dir),
    .rem_req_i(req), .rem_word_i(word), .rem_ack_o(ack),
    .sw_addr_i(sw_addr), .sw_data_i(sw_data), .enter_i(enter),
    .smp0_band_o(b0), .smp0_att_r_o(r0), .smp0_att_l_o(l0),
    .smp1_band_o(b1), .smp1_att_r_o(r1), .smp1_att_l_o(l1),
    .smp_sel_o(sel), .speed_o(spd), .lo0_freq_o(lo0), .lo1_freq_o(lo1)
  );

  function automatic logic [7:0] view(input int a);
    case (a)
      0: return {1'b0, b0, r0, l0};
      1: return {1'b0, b1, r1, l1};
      2: return {3'b0, sel, spd};
      4: return lo0;
      5: return lo1;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [39:0] all_view();
    return {view(0), view(1), view(2), view(4), view(5)};
  endfunction

  task automatic chk(input string rq, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic remote(input logic [15:0] w, input logic exp_ack, input string rq);
    @(negedge clk); word = w; req = 1'b1;
    repeat (6) @(negedge clk);
    chk(rq, 40'(ack), 40'(exp_ack));
    req = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2", 40'(ack), 40'(0));
  endtask

  task automatic hold_btn(input int n);
    @(negedge clk); enter = 1'b1;
    repeat (n) @(negedge clk);
    enter = 1'b0;
    repeat (DEB + 8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [39:0] snap;
    repeat (3) @(negedge clk);
    chk("R11", {all_view()[39:1], ack}, 40'(0));
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      remote(VEC[i][23:8], 1'b1, "R1");
      chk("R7/R8/R9", 40'(view(int'(VEC[i][23:16]))), 40'(VEC[i][7:0]));
    end
    // R7: last two sampler writes land on the right fields
    chk("R7", {36'(0), b1, r1}, {36'(0), 1'b1, 3'd0});
    chk("R7", {34'(0), b0, r0, l0}, {34'(0), 1'b1, 3'd7, 3'd7});

    // R3: direction high blocks remote
    dir = 1'b1;
    remote(16'h0411, 1'b0, "R3");
    chk("R3", 40'(lo0), 40'(8'hC3));
    dir = 1'b0;

    // R4: manual mode blocks remote
    manual = 1'b1;
    remote(16'h0522, 1'b0, "R4");
    chk("R4", 40'(lo1), 40'(8'h3C));

    // R10: unmapped acked, nothing changes
    manual = 1'b0;
    snap = all_view();
    remote(16'h03AA, 1'b1, "R10");
    chk("R10", all_view(), snap);
    remote(16'h07AA, 1'b1, "R10");
    chk("R10", all_view(), snap);

    // R5: manual write
    manual = 1'b1;
    sw_addr = 8'd5; sw_data = 8'h81;
    repeat (4) @(negedge clk);
    @(negedge clk); enter = 1'b1;
    repeat (DEB + 8) @(negedge clk);
    chk("R5", 40'(lo1), 40'(8'h81));
    // R6: held press writes once
    sw_data = 8'h22;
    repeat (DEB + 8) @(negedge clk);
    chk("R6", 40'(lo1), 40'(8'h81));
    enter = 1'b0;
    repeat (DEB + 8) @(negedge clk);
    chk("R6", 40'(lo1), 40'(8'h81));

    // R6: short glitch writes nothing
    sw_addr = 8'd4; sw_data = 8'h99;
    hold_btn(3);
    chk("R6", 40'(lo0), 40'(8'hC3));

    // R5: button ignored in remote mode
    manual = 1'b0;
    repeat (4) @(negedge clk);
    hold_btn(DEB + 8);
    chk("R5", 40'(lo0), 40'(8'hC3));

    // R11: reset mid-run clears all
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", {all_view()[39:1], ack}, 40'(0));
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule